// File: doc/BRIEF.md
# Accumulator ALU with Status Byte

This block is the arithmetic and logic datapath of a small 8-bit accumulator processor. On each cycle it takes an operation code, a primary operand (the accumulator or an index register) and a secondary operand (a memory value). It forms the result without any register in the path. A status byte holds the flags. When the operation is qualified by a valid strobe, the status byte takes its new carry, zero, overflow and negative values on the next rising clock edge.

The flag rules follow a classic 8-bit processor:
- Subtract uses an inverted borrow: carry set means no borrow.
- Compare leaves overflow alone.
- Bit test copies the top two bits of the memory operand into negative and overflow.
- Logical shift right always clears negative.

Single-operand operations (increment, decrement, shifts and rotates) work on the primary operand. The carry consumed by add, subtract and the rotates is the carry held in the status byte. The decimal flag is stored only. Separate per-bit set and clear inputs let the surrounding control logic force any status bit.

Top module: `accum_alu`

## Requirements
- R1: After reset the status byte is 0x34. Its layout is: bit 0 carry, bit 1 zero, bit 2 interrupt-disable, bit 3 decimal, bit 4 break, bit 5 spare, bit 6 overflow, bit 7 negative.
- R2: Operation code 0 (add) gives result = low 8 bits of A + M + C. The new carry is bit 8 of the sum, zero is set for a zero result, and negative is result bit 7. Overflow is set when A and M have the same sign and the result's sign differs. The decimal flag has no effect on the result.
- R3: Operation code 1 (subtract) gives result = A − M − (1 − C) modulo 256. Carry is set when no borrow leaves bit 7. Overflow is set when A and M differ in sign and the result's sign differs from A. Zero and negative follow the result.
- R4: Operation codes 2, 3 and 4 give A AND M, A OR M and A XOR M. They update zero and negative only; carry and overflow keep their values.
- R5: Operation code 5 (compare) sets carry when A ≥ M unsigned, sets zero when A = M, and sets negative from bit 7 of A − M. Overflow is unchanged and the result equals A.
- R6: Operation code 6 (bit test) sets zero when A AND M is zero, and copies M bit 6 into overflow and M bit 7 into negative. Carry is unchanged and the result equals A.
- R7: Operation codes 7 and 8 give A + 1 and A − 1, wrapping modulo 256. They update zero and negative only.
- R8: Operation code 9 (shift left) moves A bit 7 into carry and shifts in a 0. Operation code 10 (logical shift right) moves A bit 0 into carry, shifts in a 0 and always clears negative. Both set zero from the result.
- R9: Operation code 11 (rotate left) shifts the old carry into bit 0 and bit 7 into carry. Operation code 12 (rotate right) shifts the old carry into bit 7 and bit 0 into carry. Both update zero and negative.
- R10: Operation codes 13 to 15 return A and change no flag.
- R11: The result follows the inputs in the same cycle. The status byte changes only at a rising edge, and the ALU alters it only when the valid input is high at that edge.
- R12: At the same edge as any ALU update, each bit high in the clear mask is cleared and then each bit high in the set mask is set, so set wins. Bits 2 to 5 change only through these masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| valid_i | input | 1 | Lets the operation update the status byte at the next edge |
| reg_a_i | input | 8 | Primary operand (accumulator or index register) |
| mem_i | input | 8 | Secondary (memory) operand |
| flag_set_i | input | 8 | Per-bit force-to-one mask for the status byte |
| flag_clr_i | input | 8 | Per-bit force-to-zero mask for the status byte |
| result_o | output | 8 | Combinational result |
| status_o | output | 8 | Registered status byte |

## Verification
The result is combinational, so the bench reads it a short delay after driving the inputs, well before the next rising edge. It compares that value with a model that uses the flags registered before the edge. The flags are due one edge later. The bench reads the status byte just after that edge and compares it with the model's next state, including the clear and set masks. It then advances its model so the following operation consumes the carry the design actually holds. Most stimulus comes from a seeded random stream, which gives every operation code many carry, sign and zero combinations. The directed cases cover overflow boundaries, borrow out of zero, equal compare, bit-test copies, set-over-clear priority and invalid operation codes.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

   localparam int STATUS_W = 8;
   localparam int FLAG_C   = 0;
   localparam int FLAG_Z   = 1;
   localparam int FLAG_I   = 2;
   localparam int FLAG_D   = 3;
   localparam int FLAG_B   = 4;
   localparam int FLAG_U   = 5;
   localparam int FLAG_V   = 6;
   localparam int FLAG_N   = 7;

   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_CMP  = 4'd5,
      OP_BIT  = 4'd6,
      OP_INC  = 4'd7,
      OP_DEC  = 4'd8,
      OP_SHL  = 4'd9,
      OP_SHR  = 4'd10,
      OP_ROTL = 4'd11,
      OP_ROTR = 4'd12,
      OP_NONE = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic c;
      logic z;
      logic v;
      logic n;
      logic wc;
      logic wz;
      logic wv;
      logic wn;
   } flag_upd_t;

endpackage

// File: rtl/accum_alu_addsub.sv
module accum_alu_addsub
   import accum_alu_pkg::*;
#(
   parameter int W            = 8,
   parameter bit RIPPLE_ADDER = 1'b0
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   m,
   input  logic           cin,
   output logic [W-1:0]   res,
   output flag_upd_t      upd
);

   logic [W-1:0] b_eff;
   logic         c_eff;
   logic [W:0]   sum;

   always_comb begin
      case (op)
         OP_SUB:  begin b_eff = ~m;          c_eff = cin;  end
         OP_CMP:  begin b_eff = ~m;          c_eff = 1'b1; end
         OP_INC:  begin b_eff = '0;          c_eff = 1'b1; end
         OP_DEC:  begin b_eff = '1;          c_eff = 1'b0; end
         default: begin b_eff = m;           c_eff = cin;  end
      endcase
   end

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [W:0]   cc;
         logic [W-1:0] ss;
         assign cc[0] = c_eff;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign ss[i]   = a[i] ^ b_eff[i] ^ cc[i];
            assign cc[i+1] = (a[i] & b_eff[i]) | (cc[i] & (a[i] ^ b_eff[i]));
         end
         assign sum = {cc[W], ss};
      end else begin : g_behav
         assign sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
      end
   endgenerate

   assign res = sum[W-1:0];

   always_comb begin
      upd.c  = sum[W];
      upd.z  = (sum[W-1:0] == '0);
      upd.n  = sum[W-1];
      upd.v  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
      upd.wc = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
      upd.wv = (op == OP_ADD) || (op == OP_SUB);
      upd.wz = 1'b1;
      upd.wn = 1'b1;
   end

endmodule

// File: rtl/accum_alu_logic.sv
module accum_alu_logic
   import accum_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   m,
   output logic [W-1:0]   res,
   output flag_upd_t      upd
);

   logic [W-1:0] conj;
   assign conj = a & m;

   always_comb begin
      case (op)
         OP_OR:   res = a | m;
         OP_XOR:  res = a ^ m;
         OP_BIT:  res = a;
         default: res = conj;
      endcase
   end

   always_comb begin
      upd.c  = 1'b0;
      upd.wc = 1'b0;
      upd.wz = 1'b1;
      upd.wn = 1'b1;
      if (op == OP_BIT) begin
         upd.z  = (conj == '0);
         upd.n  = m[W-1];
         upd.v  = m[W-2];
         upd.wv = 1'b1;
      end else begin
         upd.z  = (res == '0);
         upd.n  = res[W-1];
         upd.v  = 1'b0;
         upd.wv = 1'b0;
      end
   end

endmodule

// File: rtl/accum_alu_shift.sv
module accum_alu_shift
   import accum_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  alu_op_e        op,
   input  logic [W-1:0]   a,
   input  logic           cin,
   output logic [W-1:0]   res,
   output flag_upd_t      upd
);

   logic left;
   logic fill;

   always_comb begin
      left = (op == OP_SHL) || (op == OP_ROTL);
      fill = ((op == OP_ROTL) || (op == OP_ROTR)) ? cin : 1'b0;
      res  = left ? {a[W-2:0], fill} : {fill, a[W-1:1]};
   end

   always_comb begin
      upd.c  = left ? a[W-1] : a[0];
      upd.z  = (res == '0);
      upd.n  = res[W-1];
      upd.v  = 1'b0;
      upd.wc = 1'b1;
      upd.wz = 1'b1;
      upd.wv = 1'b0;
      upd.wn = 1'b1;
   end

endmodule

// File: rtl/accum_alu_status.sv
module accum_alu_status
   import accum_alu_pkg::*;
#(
   parameter logic [STATUS_W-1:0] RESET_VALUE = 8'h34
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] upd_val,
   input  logic [STATUS_W-1:0] upd_we,
   input  logic [STATUS_W-1:0] set_mask,
   input  logic [STATUS_W-1:0] clr_mask,
   output logic [STATUS_W-1:0] q
);

   generate
      for (genvar i = 0; i < STATUS_W; i++) begin : g_flag
         logic nxt;
         always_comb begin
            nxt = upd_we[i] ? upd_val[i] : q[i];
            if (clr_mask[i]) nxt = 1'b0;
            if (set_mask[i]) nxt = 1'b1;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q[i] <= RESET_VALUE[i];
            else        q[i] <= nxt;
         end
      end
   endgenerate

   // R12: a set bit is one after the edge
   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((q & $past(set_mask)) == $past(set_mask)));

   // R12: a cleared bit without a set is zero after the edge
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~set_mask) != '0) |=> ((q & $past(clr_mask & ~set_mask)) == '0));

   // R12: control bits 2..5 hold without set or clear
   a_r12_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask == '0 && clr_mask == '0) |=> (q[FLAG_U:FLAG_I] == $past(q[FLAG_U:FLAG_I])));

endmodule

// File: rtl/accum_alu.sv
module accum_alu
   import accum_alu_pkg::*;
#(
   parameter int                  W            = 8,
   parameter bit                  RIPPLE_ADDER = 1'b0,
   parameter logic [STATUS_W-1:0] RESET_VALUE  = 8'h34
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [3:0]          op_i,
   input  logic                valid_i,
   input  logic [W-1:0]        reg_a_i,
   input  logic [W-1:0]        mem_i,
   input  logic [STATUS_W-1:0] flag_set_i,
   input  logic [STATUS_W-1:0] flag_clr_i,
   output logic [W-1:0]        result_o,
   output logic [STATUS_W-1:0] status_o
);

   generate
      if (W < 3) begin : g_bad_width
         $error("accum_alu: W must be at least 3");
      end
   endgenerate

   alu_op_e      op;
   logic         carry_q;
   logic [W-1:0] as_res, lg_res, sh_res;
   flag_upd_t    as_upd, lg_upd, sh_upd, sel_upd;

   assign op      = alu_op_e'(op_i);
   assign carry_q = status_o[FLAG_C];

   accum_alu_addsub #(.W(W), .RIPPLE_ADDER(RIPPLE_ADDER)) u_addsub (
      .op(op), .a(reg_a_i), .m(mem_i), .cin(carry_q), .res(as_res), .upd(as_upd));

   accum_alu_logic #(.W(W)) u_logic (
      .op(op), .a(reg_a_i), .m(mem_i), .res(lg_res), .upd(lg_upd));

   accum_alu_shift #(.W(W)) u_shift (
      .op(op), .a(reg_a_i), .cin(carry_q), .res(sh_res), .upd(sh_upd));

   always_comb begin
      sel_upd  = '0;
      result_o = reg_a_i;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            result_o = as_res;
            sel_upd  = as_upd;
         end
         OP_CMP: begin
            sel_upd  = as_upd;
         end
         OP_AND, OP_OR, OP_XOR, OP_BIT: begin
            result_o = lg_res;
            sel_upd  = lg_upd;
         end
         OP_SHL, OP_SHR, OP_ROTL, OP_ROTR: begin
            result_o = sh_res;
            sel_upd  = sh_upd;
         end
         default: begin
            result_o = reg_a_i;
            sel_upd  = '0;
         end
      endcase
   end

   logic [STATUS_W-1:0] upd_val, upd_we;

   always_comb begin
      upd_val         = '0;
      upd_we          = '0;
      upd_val[FLAG_C] = sel_upd.c;
      upd_val[FLAG_Z] = sel_upd.z;
      upd_val[FLAG_V] = sel_upd.v;
      upd_val[FLAG_N] = sel_upd.n;
      upd_we[FLAG_C]  = valid_i & sel_upd.wc;
      upd_we[FLAG_Z]  = valid_i & sel_upd.wz;
      upd_we[FLAG_V]  = valid_i & sel_upd.wv;
      upd_we[FLAG_N]  = valid_i & sel_upd.wn;
   end

   accum_alu_status #(.RESET_VALUE(RESET_VALUE)) u_status (
      .clk(clk), .rst_n(rst_n), .upd_val(upd_val), .upd_we(upd_we),
      .set_mask(flag_set_i), .clr_mask(flag_clr_i), .q(status_o));

   logic no_force;
   assign no_force = (flag_set_i == '0) && (flag_clr_i == '0);

   // R11: without valid and masks the status byte holds
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && no_force) |=> $stable(status_o));

   // R8: logical shift right leaves negative clear
   a_r8_shr_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && no_force && op == OP_SHR) |=> !status_o[FLAG_N]);

   // R5: compare keeps overflow
   a_r5_cmp_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && no_force && op == OP_CMP) |=> (status_o[FLAG_V] == $past(status_o[FLAG_V])));

   // R6: bit test copies the operand's top bits
   a_r6_bit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && no_force && op == OP_BIT) |=>
         (status_o[FLAG_V] == $past(mem_i[W-2]) && status_o[FLAG_N] == $past(mem_i[W-1])));

   // R7: increment and decrement keep carry
   a_r7_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && no_force && (op == OP_INC || op == OP_DEC)) |=>
         (status_o[FLAG_C] == $past(status_o[FLAG_C])));

   // R10: unused codes change no flag
   a_r10_idle_op: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && no_force && op_i > 4'd12) |=> $stable(status_o));

endmodule

// File: tb/accum_alu_test.sv
module accum_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = '0;
   logic       valid_i = 1'b0;
   logic [7:0] reg_a_i = '0;
   logic [7:0] mem_i = '0;
   logic [7:0] flag_set_i = '0;
   logic [7:0] flag_clr_i = '0;
   logic [7:0] result_o;
   logic [7:0] status_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] model_st;

   always #5 clk = ~clk;

   accum_alu uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .valid_i(valid_i),
      .reg_a_i(reg_a_i), .mem_i(mem_i), .flag_set_i(flag_set_i),
      .flag_clr_i(flag_clr_i), .result_o(result_o), .status_o(status_o));

   function automatic string tag_of(input int op);
      case (op)
         0: return "R2";
         1: return "R3";
         2, 3, 4: return "R4";
         5: return "R5";
         6: return "R6";
         7, 8: return "R7";
         9, 10: return "R8";
         11, 12: return "R9";
         default: return "R10";
      endcase
   endfunction

   // returns {result, next status} without masks
   function automatic logic [15:0] ref_step(input int op, input int a, input int m, input logic [7:0] st);
      int r, s;
      logic [7:0] n;
      logic c;
      n = st;
      c = st[0];
      r = a;
      case (op)
         0: begin
            s = a + m + int'(c); r = s & 255;
            n[0] = s > 255;
            n[6] = (((a ^ r) & (m ^ r) & 128) != 0);
         end
         1: begin
            s = a - m - (1 - int'(c)); r = s & 255;
            n[0] = s >= 0;
            n[6] = (((a ^ m) & (a ^ r) & 128) != 0);
         end
         2: r = a & m;
         3: r = a | m;
         4: r = a ^ m;
         5: begin
            n[0] = a >= m; n[1] = a == m; n[7] = (((a - m) & 128) != 0);
         end
         6: begin
            n[1] = (a & m) == 0; n[6] = m[6]; n[7] = m[7];
         end
         7: r = (a + 1) & 255;
         8: r = (a + 255) & 255;
         9:  begin n[0] = a[7]; r = (a * 2) & 255; end
         10: begin n[0] = a[0]; r = a / 2; end
         11: begin n[0] = a[7]; r = ((a * 2) & 255) + int'(c); end
         12: begin n[0] = a[0]; r = (a / 2) + (c ? 128 : 0); end
         default: r = a;
      endcase
      if (op <= 4 || (op >= 7 && op <= 12)) begin
         n[1] = (r == 0);
         n[7] = r[7];
      end
      return {r[7:0], n};
   endfunction

   task automatic check8(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic step(input int op, input int a, input int m, input logic v,
                       input logic [7:0] setm, input logic [7:0] clrm);
      logic [15:0] e;
      logic [7:0]  nxt;
      string       t;
      @(negedge clk);
      op_i = op[3:0]; reg_a_i = a[7:0]; mem_i = m[7:0];
      valid_i = v; flag_set_i = setm; flag_clr_i = clrm;
      #1;
      e = ref_step(op, a, m, model_st);
      check8(tag_of(op), "result", result_o, e[15:8]);
      nxt = v ? e[7:0] : model_st;
      nxt = (nxt & ~clrm) | setm;
      if (setm != 0 || clrm != 0) t = "R12";
      else if (!v) t = "R11";
      else t = tag_of(op);
      @(posedge clk);
      #1;
      check8(t, "status", status_o, nxt);
      model_st = status_o;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5813));
      repeat (3) @(posedge clk);
      #1;
      check8("R1", "reset status", status_o, 8'h34);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check8("R1", "status after release", status_o, 8'h34);
      model_st = 8'h34;

      // R2 overflow, carry out, zero
      step(0, 8'h50, 8'h50, 1, 0, 0);
      step(0, 8'hFF, 8'h01, 1, 0, 0);
      step(0, 8'h10, 8'h20, 1, 0, 0);   // carry in from previous
      // R2 decimal flag set has no effect
      step(15, 0, 0, 1, 8'h08, 0);
      step(0, 8'h09, 8'h01, 1, 0, 8'h01);
      step(0, 8'h09, 8'h01, 1, 0, 0);
      // R3 borrow out of zero, overflow
      step(1, 8'h00, 8'h01, 1, 0, 8'h01);
      step(1, 8'h50, 8'hB0, 1, 8'h01, 0);
      step(1, 8'h80, 8'h01, 1, 8'h01, 0);
      // R4
      step(2, 8'hF0, 8'h0F, 1, 0, 0);
      step(3, 8'h80, 8'h01, 1, 0, 0);
      step(4, 8'hAA, 8'hAA, 1, 0, 0);
      // R5 equal, less, greater with overflow preset
      step(15, 0, 0, 1, 8'h40, 0);
      step(5, 8'h42, 8'h42, 1, 0, 0);
      step(5, 8'h10, 8'h20, 1, 0, 0);
      step(5, 8'hF0, 8'h01, 1, 0, 0);
      // R6
      step(6, 8'h0F, 8'hC0, 1, 0, 0);
      step(6, 8'h01, 8'h01, 1, 0, 0);
      // R7 wrap
      step(7, 8'hFF, 0, 1, 0, 0);
      step(8, 8'h00, 0, 1, 0, 0);
      // R8
      step(9, 8'h80, 0, 1, 0, 0);
      step(10, 8'h01, 0, 1, 8'h80, 0);
      step(10, 8'hFE, 0, 1, 0, 0);
      // R9 carry in
      step(12, 8'h02, 0, 1, 8'h01, 0);
      step(11, 8'h81, 0, 1, 0, 8'h01);
      // R10
      step(13, 8'h00, 8'hFF, 1, 0, 0);
      step(14, 8'h80, 8'hFF, 1, 0, 0);
      // R11 no valid
      step(0, 8'hFF, 8'hFF, 0, 0, 0);
      // R12 set wins over clear, any bit
      step(0, 8'h01, 8'h01, 1, 8'h05, 8'hFF);
      step(15, 0, 0, 0, 8'h00, 8'h3C);

      for (int k = 0; k < 3000; k++) begin
         int op;
         logic v;
         logic [7:0] sm, cm;
         op = int'($urandom_range(15, 0));
         v  = ($urandom_range(7, 0) != 0);
         sm = ($urandom_range(9, 0) == 0) ? 8'($urandom) : 8'h00;
         cm = ($urandom_range(9, 0) == 0) ? 8'($urandom) : 8'h00;
         step(op, int'($urandom_range(255, 0)), int'($urandom_range(255, 0)), v, sm, cm);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule